// File: doc/BRIEF.md
# Banked Input Port Interrupt Controller

This block is the register file of a 48-line digital input card. The lines form two 24-bit ports, and each port splits into three 8-bit banks, six banks in all. A host reaches the block through a byte-wide read/write bus over an eight-byte address window. Six of the offsets return the live, synchronised input bytes. The last offset returns the interrupt status on a read and loads the per-bank interrupt enables on a write.

Each input line passes through a two-stage synchroniser. A bank's pending flag is set whenever any of its eight synchronised lines changes value, but only while that bank is enabled. The block drives one interrupt output that stays high while any enabled bank is pending. A host reads the status offset to see which banks fired, and that same read clears all pending flags. The host chooses which banks may interrupt by writing a six-bit enable mask. Masking works per bank, so a cleared enable bit masks all eight lines of that bank.

Top module: `bank_irq_regs`

## Requirements
- R1: Offsets 0, 1 and 2 read synchronised lines [7:0], [15:8] and [23:16]. Offsets 4, 5 and 6 read lines [31:24], [39:32] and [47:40]. Bank b is lines [8b+7:8b].
- R2: Offset 3 reads 8'hFF. Writes to offsets 0 to 6 change neither the read data nor the interrupt state.
- R3: Bits 5:0 of the offset 7 read value are the pending flags, with bank b at bit b.
- R4: Bit 6 of the offset 7 read value is 0 when at least one enabled bank is pending, and 1 otherwise.
- R5: Bit 7 of the offset 7 read value is 1 when at least one enable bit is set.
- R6: A read of offset 7 clears every pending flag at that clock edge. The interrupt output is low after the edge unless a new change arrives.
- R7: A write to offset 7 loads bits 5:0 as the bank enables. Bits 7:6 are ignored, and the write leaves the pending flags unchanged.
- R8: A change on a disabled bank never sets that bank's pending flag, and enabling the bank later does not set it either.
- R9: A change that is detected in the same cycle as a status read leaves that bank's pending flag set after the clear.
- R10: irq_o is high exactly while some bank is both enabled and pending.
- R11: After reset, the enables and pending flags are 0, irq_o is low and the status read gives 8'h40.
- R12: A change driven on an input line sets the pending flag at the third rising clock edge, not earlier: two edges of synchronisation and one edge of comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe; reading offset 7 clears pending flags |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| lines_i | input | 48 | Asynchronous input lines |
| irq_o | output | 1 | Interrupt, high while an enabled bank is pending |

## Verification
The bench builds the block with its default parameters: six banks of eight lines and two synchroniser stages. With these values the full address map is reachable, including the unused offset and both port halves. Random enable masks make it possible to mix enabled and masked banks in a single change event. Because the synchroniser depth is the default, the bench can place a status read in the exact cycle a change is first compared, which covers the clear-versus-set collision. It can also check that no pending flag appears before the third edge.

// File: rtl/bank_irq_pkg.sv
package bank_irq_pkg;
    localparam int NUM_BANKS   = 6;
    localparam int BANK_W      = 8;
    localparam int NUM_LINES   = NUM_BANKS * BANK_W;
    localparam int ADDR_W      = 3;
    localparam int DATA_W      = 8;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 3'd7;
    localparam logic [ADDR_W-1:0] HOLE_ADDR   = 3'd3;
    localparam logic [DATA_W-1:0] HOLE_VALUE  = 8'hFF;

    typedef struct packed {
        logic [NUM_BANKS-1:0] en;
        logic [NUM_BANKS-1:0] pend;
    } irq_state_t;
endpackage

// File: rtl/bank_irq_sync.sv
module bank_irq_sync #(
    parameter int BANKS  = bank_irq_pkg::NUM_BANKS,
    parameter int WIDTH  = bank_irq_pkg::BANK_W,
    parameter int STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BANKS*WIDTH-1:0] lines_i,
    output logic [BANKS*WIDTH-1:0] synced_o,
    output logic [BANKS-1:0]       bank_chg_o
);
    localparam int LINES = BANKS * WIDTH;

    logic [LINES-1:0] stage_d [STAGES];
    logic [LINES-1:0] stage_q [STAGES];
    logic [LINES-1:0] prev_d, prev_q;

    always_comb begin
        stage_d[0] = lines_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
        prev_d = stage_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
            prev_q <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
            prev_q <= prev_d;
        end
    end

    assign synced_o = stage_q[STAGES-1];

    for (genvar b = 0; b < BANKS; b++) begin : g_chg
        assign bank_chg_o[b] = |(stage_q[STAGES-1][b*WIDTH +: WIDTH] ^ prev_q[b*WIDTH +: WIDTH]);
    end
endmodule

// File: rtl/bank_irq_pend.sv
module bank_irq_pend
    import bank_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 en_wr_i,
    input  logic [NUM_BANKS-1:0] en_wdata_i,
    input  logic [NUM_BANKS-1:0] chg_i,
    output logic [NUM_BANKS-1:0] en_o,
    output logic [NUM_BANKS-1:0] pend_o,
    output logic                 irq_o
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr_i) begin
            st_d.en = en_wdata_i;
        end
        if (clr_i) begin
            st_d.pend = '0;
        end
        st_d.pend = st_d.pend | (chg_i & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign irq_o  = |(st_q.pend & st_q.en);

    // R6
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && chg_i == '0) |=> pend_o == '0);

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & $past(~pend_o & ~en_o)) == '0));

    // R3
    sticky_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

    // R7
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> en_o == $past(en_wdata_i));

    // R9
    collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> pend_o == $past(chg_i & en_o));
endmodule

// File: rtl/bank_irq_rdmux.sv
module bank_irq_rdmux
    import bank_irq_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [NUM_LINES-1:0] synced_i,
    input  logic [NUM_BANKS-1:0] en_i,
    input  logic [NUM_BANKS-1:0] pend_i,
    input  logic                 irq_i,
    output logic [DATA_W-1:0]    rdata_o
);
    localparam int HALF = NUM_BANKS / 2;

    logic [BANK_W-1:0] bytes [NUM_BANKS];
    logic [$clog2(NUM_BANKS)-1:0] sel;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bytes
        assign bytes[b] = synced_i[b*BANK_W +: BANK_W];
    end

    always_comb begin
        sel = '0;
        if (addr_i[2]) begin
            sel = 3'(HALF) + 3'(addr_i[1:0]);
        end else begin
            sel = 3'(addr_i[1:0]);
        end
        if (addr_i == STATUS_ADDR) begin
            rdata_o = {|en_i, ~irq_i, pend_i};
        end else if (addr_i == HOLE_ADDR) begin
            rdata_o = HOLE_VALUE;
        end else begin
            rdata_o = bytes[sel];
        end
    end
endmodule

// File: rtl/bank_irq_regs.sv
module bank_irq_regs
    import bank_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] lines_i,
    output logic                 irq_o
);
    logic [NUM_LINES-1:0] synced;
    logic [NUM_BANKS-1:0] chg, en, pend;
    logic                 clr, en_wr;

    assign clr   = bus_rd && (bus_addr == STATUS_ADDR);
    assign en_wr = bus_wr && (bus_addr == STATUS_ADDR);

    bank_irq_sync #(
        .BANKS(NUM_BANKS), .WIDTH(BANK_W), .STAGES(2)
    ) sync_i (
        .clk(clk), .rst_n(rst_n), .lines_i(lines_i),
        .synced_o(synced), .bank_chg_o(chg)
    );

    bank_irq_pend pend_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_wr_i(en_wr),
        .en_wdata_i(bus_wdata[NUM_BANKS-1:0]), .chg_i(chg),
        .en_o(en), .pend_o(pend), .irq_o(irq_o)
    );

    bank_irq_rdmux rdmux_i (
        .addr_i(bus_addr), .synced_i(synced), .en_i(en),
        .pend_i(pend), .irq_i(irq_o), .rdata_o(bus_rdata)
    );

    // R4
    summary_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == STATUS_ADDR) |-> (bus_rdata[6] == !irq_o));

    // R2
    hole_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == HOLE_ADDR) |-> (bus_rdata == HOLE_VALUE));

    // R10
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && chg == '0) |=> !irq_o);
endmodule

// File: tb/bank_irq_regs_tb_top.sv
module bank_irq_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] lines = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_en = '0;
    logic [5:0] exp_pend = '0;

    always #4 clk = ~clk;

    bank_irq_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lines_i(lines), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        if (a == 3'd7) return {|exp_en, ~|(exp_pend & exp_en), exp_pend};
        if (a == 3'd3) return 8'hFF;
        if (a[2])      return lines[(32'(a[1:0]) + 3) * 8 +: 8];
        return lines[32'(a[1:0]) * 8 +: 8];
    endfunction

    task automatic bus_read(input logic [2:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(req, bus_rdata, exp_read(a));
        @(negedge clk);
        bus_rd = 1'b0;
        if (a == 3'd7) exp_pend = '0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 3'd7) exp_en = d[5:0];
    endtask

    task automatic apply_lines(input logic [47:0] nv);
        @(negedge clk);
        for (int b = 0; b < 6; b++) begin
            if (nv[b*8 +: 8] != lines[b*8 +: 8] && exp_en[b]) exp_pend[b] = 1'b1;
        end
        lines = nv;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_irq(input string req);
        check(req, {7'd0, irq_o}, {7'd0, |(exp_pend & exp_en)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd915));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        check("R11", {7'd0, irq_o}, 8'h00);
        bus_read(3'd7, "R11");
        // R1 port bytes, distinct values per bank
        apply_lines(48'h665544332211);
        for (int a = 0; a < 7; a++) bus_read(3'(a), "R1");
        // R2 writes to data offsets are ignored
        for (int a = 0; a < 7; a++) begin
            bus_write(3'(a), 8'h5A);
            bus_read(3'(a), "R2");
        end
        // R5 / R7 enable write, upper bits ignored
        bus_write(3'd7, 8'hC5);
        bus_read(3'd7, "R7");
        // R12 latency: bank 0 enabled
        @(negedge clk);
        lines[0] = ~lines[0];
        @(negedge clk); @(negedge clk);
        check("R12", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        check("R12", {7'd0, irq_o}, 8'h01);
        exp_pend[0] = 1'b1;
        // R3 / R4 status with pending
        bus_read(3'd7, "R3");
        // R6 cleared
        check("R6", {7'd0, irq_o}, 8'h00);
        bus_read(3'd7, "R6");
        // R8 change on disabled bank 1, then enable it
        apply_lines(lines ^ 48'h0000_0000_FF00);
        check_irq("R8");
        bus_write(3'd7, 8'h3F);
        repeat (2) @(negedge clk);
        bus_read(3'd7, "R8");
        // R7 write keeps pending
        apply_lines(lines ^ 48'h0000_0001_0000);
        bus_write(3'd7, 8'h04);
        bus_read(3'd7, "R7");
        // R4 pending on bank now masked
        bus_write(3'd7, 8'h3F);
        apply_lines(lines ^ 48'h0001_0000_0000);
        bus_write(3'd7, 8'h0F);
        check_irq("R4");
        bus_read(3'd7, "R4");
        // R9 change detected in the same cycle as a status read
        bus_write(3'd7, 8'h3F);
        @(negedge clk);
        lines[47] = ~lines[47];
        @(negedge clk);
        @(negedge clk);
        bus_addr = 3'd7; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        exp_pend = 6'b100000;
        check_irq("R9");
        bus_read(3'd7, "R9");
        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: begin
                    logic [47:0] nv;
                    nv = lines;
                    for (int b = 0; b < 6; b++)
                        if ($urandom_range(0, 2) == 0) nv[b*8 +: 8] = 8'($urandom);
                    apply_lines(nv);
                end
                1: bus_write(3'd7, 8'($urandom));
                2: bus_read(3'd7, "R3");
                3: bus_read(3'($urandom_range(0, 6)), "R1");
                default: begin
                    logic [2:0] a;
                    a = 3'($urandom_range(0, 6));
                    bus_write(a, 8'($urandom));
                    bus_read(a, "R2");
                end
            endcase
            check_irq("R10");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule